// File: doc/BRIEF.md
# Calibrated ADC Offset Canceller

This block removes a constant DC error from a stream of signed 12-bit converter samples. Out of reset it measures the error on its own. An integrate-and-dump averager sums a window of 2^K accepted samples and shifts the sum right by K to get the mean. That mean is loaded into an offset register. From then on, every sample has the stored offset taken away by one subtractor, and the result is clamped to the 12-bit range. The output is registered.

The controller is a four-state machine:
- **ST_CAL** is the first measurement after reset. On the window dump it moves to ST_TRACK if `track_en` is high, and to ST_HOLD otherwise.
- **ST_HOLD** applies the stored offset and keeps the averager cleared. A `cal_req` pulse moves it to ST_RECAL. Otherwise, `track_en` high moves it to ST_TRACK. `cal_req` has priority.
- **ST_RECAL** measures one new window while the old offset stays in use. On the dump it returns to ST_HOLD.
- **ST_TRACK** runs windows back to back and reloads the offset at the end of each one, so the offset follows slow drift. It returns to ST_HOLD when `track_en` falls, and the partial window is then thrown away.

`cal_done` goes high once the first offset is in place. It stays high until reset.

Top module: `dc_trim_top`

## Requirements
- R1: During and right after reset, `out_valid` and `cal_done` are 0 and `out_data` is 0, with the machine in ST_CAL.
- R2: `out_valid` equals `in_valid` delayed by exactly one clock. Each accepted sample yields its result on the next clock.
- R3: Until the first offset is loaded, the stored offset is 0. `out_data` then equals the sample taken one clock earlier.
- R4: A measurement window closes on its 2^K-th accepted sample. The offset becomes the floor of the window sum divided by 2^K, and it is loaded on the clock after that sample.
- R5: `cal_done` rises exactly one clock after the first offset load and never falls before reset.
- R6: Samples and results are two's complement. For every accepted sample, `out_data` = `in_data` − offset, using the offset held before the same clock edge.
- R7: A difference above 2047 gives 2047, and a difference below −2048 gives −2048. The result never wraps.
- R8: A `cal_req` pulse in ST_HOLD starts one new window. The old offset keeps being applied until the new one is loaded at the end of that window.
- R9: With `track_en` high after calibration, the offset reloads once every 2^K accepted samples. When `track_en` drops, the machine returns to ST_HOLD and drops the partial sum.
- R10: The offset register changes only on the clock after a window closes.
- R11: Clocks with `in_valid` low add nothing to a window and do not advance its count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample qualifier |
| in_data | input | 12 | Signed input sample |
| cal_req | input | 1 | Request for one fresh offset measurement |
| track_en | input | 1 | Enables continuous re-measurement |
| cal_done | output | 1 | First offset has been loaded |
| out_valid | output | 1 | Output sample qualifier |
| out_data | output | 12 | Signed corrected sample |

## Verification
The bench builds the block with K=4, which gives 16-sample windows. With that size, the first calibration, a requested re-measurement, and two full tracking windows plus a partial one all fit in a few hundred clocks. The window offsets are chosen so that the corrected results are driven into both saturation limits. Gaps in `in_valid` inside a window show that idle clocks do not count. The default K=10 keeps the same control path and only widens the accumulator and the counter.

// File: rtl/dc_trim_pkg.sv
package dc_trim_pkg;
    typedef enum logic [1:0] {
        ST_CAL   = 2'd0,
        ST_HOLD  = 2'd1,
        ST_RECAL = 2'd2,
        ST_TRACK = 2'd3
    } trim_state_e;
endpackage

// File: rtl/dc_trim_cic.sv
// Integrate-and-dump mean estimator over 2**K accepted samples.
module dc_trim_cic #(
    parameter int DW = 12,
    parameter int K  = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          run,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    output logic          dump_o,
    output logic [DW-1:0] mean_o
);
    localparam int AW = DW + K;

    logic [AW-1:0] acc_q;
    logic [AW-1:0] sum_w;
    logic [K-1:0]  cnt_q;
    logic          last_w;

    assign sum_w  = acc_q + {{K{in_data[DW-1]}}, in_data};
    assign last_w = &cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            cnt_q  <= '0;
            dump_o <= 1'b0;
            mean_o <= '0;
        end else if (clr) begin
            acc_q  <= '0;
            cnt_q  <= '0;
            dump_o <= 1'b0;
        end else begin
            dump_o <= 1'b0;
            if (run && in_valid) begin
                if (last_w) begin
                    acc_q  <= '0;
                    cnt_q  <= '0;
                    dump_o <= 1'b1;
                    mean_o <= sum_w[AW-1:K];
                end else begin
                    acc_q <= sum_w;
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/dc_trim_ctrl.sv
// Calibration sequencer and offset register.
module dc_trim_ctrl
    import dc_trim_pkg::*;
#(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cal_req,
    input  logic          track_en,
    input  logic          dump_i,
    input  logic [DW-1:0] mean_i,
    output logic          cic_clr,
    output logic          cic_run,
    output logic [DW-1:0] offset_o,
    output logic          offset_ok_o,
    output logic          done_o
);
    trim_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CAL: begin
                if (dump_i) state_d = track_en ? ST_TRACK : ST_HOLD;
            end
            ST_HOLD: begin
                if (cal_req)       state_d = ST_RECAL;
                else if (track_en) state_d = ST_TRACK;
            end
            ST_RECAL: begin
                if (dump_i) state_d = ST_HOLD;
            end
            ST_TRACK: begin
                if (!track_en) state_d = ST_HOLD;
            end
            default: state_d = ST_CAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_CAL;
        else        state_q <= state_d;
    end

    assign cic_clr = (state_q == ST_HOLD);
    assign cic_run = !cic_clr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            offset_o    <= '0;
            offset_ok_o <= 1'b0;
            done_o      <= 1'b0;
        end else begin
            done_o <= offset_ok_o;
            if (dump_i) begin
                offset_o    <= mean_i;
                offset_ok_o <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/dc_trim_sub.sv
// Registered offset subtraction with saturation to DW bits.
module dc_trim_sub #(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    input  logic [DW-1:0] offset,
    output logic          out_valid,
    output logic [DW-1:0] out_data
);
    localparam logic [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};

    logic [DW:0]   diff_w;
    logic [DW-1:0] sat_w;

    assign diff_w = {in_data[DW-1], in_data} - {offset[DW-1], offset};

    always_comb begin
        if (diff_w[DW] != diff_w[DW-1]) sat_w = diff_w[DW] ? MINV : MAXV;
        else                            sat_w = diff_w[DW-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_data <= sat_w;
        end
    end
endmodule

// File: rtl/dc_trim_top.sv
module dc_trim_top #(
    parameter int DW = 12,
    parameter int K  = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    input  logic          cal_req,
    input  logic          track_en,
    output logic          cal_done,
    output logic          out_valid,
    output logic [DW-1:0] out_data
);
    logic          cic_clr;
    logic          cic_run;
    logic          cic_dump;
    logic [DW-1:0] cic_mean;
    logic [DW-1:0] offset_q;
    logic          offset_ok;

    dc_trim_cic #(.DW(DW), .K(K)) u_cic (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cic_clr),
        .run      (cic_run),
        .in_valid (in_valid),
        .in_data  (in_data),
        .dump_o   (cic_dump),
        .mean_o   (cic_mean)
    );

    dc_trim_ctrl #(.DW(DW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cal_req     (cal_req),
        .track_en    (track_en),
        .dump_i      (cic_dump),
        .mean_i      (cic_mean),
        .cic_clr     (cic_clr),
        .cic_run     (cic_run),
        .offset_o    (offset_q),
        .offset_ok_o (offset_ok),
        .done_o      (cal_done)
    );

    dc_trim_sub #(.DW(DW)) u_sub (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .offset    (offset_q),
        .out_valid (out_valid),
        .out_data  (out_data)
    );
endmodule

// File: rtl/dc_trim_chk.sv
module dc_trim_chk #(
    parameter int DW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [DW-1:0] in_data,
    input logic          cal_done,
    input logic          out_valid,
    input logic [DW-1:0] out_data,
    input logic          offset_ok,
    input logic          dump,
    input logic [DW-1:0] offset
);
    // R2
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R2
    valid_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R3
    passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !offset_ok) |=> (out_data == $past(in_data)));
    // R5
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done |=> cal_done);
    // R5
    done_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal_done) |-> $past(offset_ok));
    // R10
    offset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dump |=> $stable(offset));
endmodule

bind dc_trim_top dc_trim_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .cal_done  (cal_done),
    .out_valid (out_valid),
    .out_data  (out_data),
    .offset_ok (offset_ok),
    .dump      (cic_dump),
    .offset    (offset_q)
);

// File: tb/tb_dc_trim_top.sv
module tb_dc_trim_top;
    localparam int DW = 12;
    localparam int K  = 4;
    localparam int R  = 1 << K;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          cal_req = 1'b0;
    logic          track_en = 1'b0;
    logic          cal_done;
    logic          out_valid;
    logic [DW-1:0] out_data;

    int nchk = 0;
    int nerr = 0;

    dc_trim_top #(.DW(DW), .K(K)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .cal_req(cal_req), .track_en(track_en), .cal_done(cal_done),
        .out_valid(out_valid), .out_data(out_data)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int sat(input int v);
        if (v > 2047)  return 2047;
        if (v < -2048) return -2048;
        return v;
    endfunction

    // Behavioural reference: 0 cal, 1 hold, 2 recal, 3 track
    int    m_state, m_acc, m_cnt, m_dump, m_dval, m_off, m_ok, m_done, m_ov, m_od;
    string m_tag = "R6";

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_acc = 0; m_cnt = 0; m_dump = 0; m_dval = 0;
            m_off = 0; m_ok = 0; m_done = 0; m_ov = 0; m_od = 0;
        end else begin
            int s;
            int nstate;
            int raw;
            s = $signed(in_data);
            m_ov = in_valid;
            if (in_valid) begin
                raw  = s - m_off;
                m_od = sat(raw);
                if (m_ok == 0)          m_tag = "R3";
                else if (raw != m_od)   m_tag = "R7";
                else                    m_tag = "R6";
            end
            m_done = m_ok;
            nstate = m_state;
            case (m_state)
                0: if (m_dump != 0) nstate = track_en ? 3 : 1;
                1: if (cal_req) nstate = 2; else if (track_en) nstate = 3;
                2: if (m_dump != 0) nstate = 1;
                default: if (!track_en) nstate = 1;
            endcase
            if (m_dump != 0) begin
                m_off = m_dval;
                m_ok  = 1;
            end
            if (m_state == 1) begin
                m_acc = 0; m_cnt = 0; m_dump = 0;
            end else if (in_valid) begin
                if (m_cnt == R - 1) begin
                    m_dval = (m_acc + s) >>> K;
                    m_dump = 1; m_acc = 0; m_cnt = 0;
                end else begin
                    m_acc += s; m_cnt++; m_dump = 0;
                end
            end else begin
                m_dump = 0;
            end
            m_state = nstate;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            check("R2", int'(out_valid), m_ov);
            check("R5", int'(cal_done), m_done);
            if (m_ov != 0) check(m_tag, $signed(out_data), m_od);
        end
    end

    task automatic send(input logic v, input int d);
        in_valid = v;
        in_data  = d[DW-1:0];
        @(negedge clk);
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1
        check("R1", int'(out_valid), 0);
        check("R1", int'(cal_done), 0);
        check("R1", int'(out_data), 0);
        rst_n = 1'b1;

        // First calibration: mean 300, with idle gaps (R11)
        for (int i = 0; i < R; i++) begin
            send(1'b1, (i % 2 == 1) ? 305 : 295);
            if (i == 0) check("R3", $signed(out_data), 295);
            if (i % 3 == 0) send(1'b0, 0);
        end
        repeat (3) send(1'b0, 0);
        check("R5", int'(cal_done), 1);
        send(1'b1, 300);   check("R4", $signed(out_data), 0);
        send(1'b1, 1000);  check("R6", $signed(out_data), 700);
        send(1'b1, -2048); check("R7", $signed(out_data), -2048);
        send(1'b0, 0);     check("R11", int'(out_valid), 0);

        // Requested re-measurement of -500
        cal_req = 1'b1;
        send(1'b0, 0);
        cal_req = 1'b0;
        for (int i = 0; i < R; i++) begin
            send(1'b1, -500);
            if (i == 0) check("R8", $signed(out_data), -800);
        end
        repeat (3) send(1'b0, 0);
        send(1'b1, -500); check("R8", $signed(out_data), 0);
        send(1'b1, 1800); check("R7", $signed(out_data), 2047);

        // Tracking: ramp, two full windows then a partial one
        track_en = 1'b1;
        send(1'b0, 0);
        for (int i = 0; i < 40; i++) send(1'b1, i * 8 - 100);
        track_en = 1'b0;
        repeat (3) send(1'b0, 0);
        send(1'b1, 88); check("R9", $signed(out_data), 0);
        send(1'b1, 0);  check("R10", $signed(out_data), -88);
        repeat (2) send(1'b0, 0);
        finish_run();
    end
endmodule